// File: doc/BRIEF.md
# System Management I/O Restart Sequencer

This block sequences entry into and return from system management mode when a management interrupt request arrives while an I/O instruction is being trapped. On each entry it presents two values that the handler reads: a 32-bit restart slot, cleared on entry, and a trap doubleword whose bit 1 tells the handler whether a valid I/O instruction was trapped. The handler may write the restart slot. On resume, the value in the slot decides whether the trapped I/O instruction runs again or execution moves on to the next instruction.

A breakpoint hit that coincides with the request is held back until after resume. If a re-execution was requested, the held-back breakpoint is also delayed until after the re-execution. A second request that arrives between resume and re-execution is serviced first. That nested entry never reports a valid trap, and the outer re-execution request survives it. The block raises single-cycle pulses to the core in a fixed order: first either re-execute or advance, then the breakpoint.

Top module: `smm_restart_seq`

## Requirements
- R1: A request on `smi_req` while the block is in normal execution raises `in_smm` after one clock edge. `in_smm` only rises after a request.
- R2: The restart slot reads 0 after every entry, including nested ones. Bits 31:16 always read as zero, and any value written to them is discarded.
- R3: On entry from normal execution, bit 1 of `trap_dw` equals `io_trap AND io_valid`. All other bits of `trap_dw` read zero.
- R4: Restart code 16'h00FF in the slot at `rsm` makes the block pulse `reexec_pulse` one cycle after the resume-decision cycle. Any other code makes it pulse `adv_pulse` in that cycle instead. Each resume gives exactly one of these two pulses.
- R5: A request that is present in the resume-decision cycle starts a nested entry before any re-execute or advance pulse. In the nested entry, bit 1 of `trap_dw` reads 0. A re-execution armed before the nested entry is still carried out after the nested resume.
- R6: `dbg_hit` sampled on entry from normal execution gives one `dbg_pulse`. The pulse comes one cycle after the re-execute or advance pulse, and never while `in_smm` is high.
- R7: A write of code 16'h00FF while bit 1 of `trap_dw` is clear leaves the slot unchanged and sets the sticky `wr_err`.
- R8: Slot writes made outside system management mode have no effect on the slot or on `wr_err`.
- R9: Reset clears the slot, `trap_dw`, `wr_err`, all pending state and all pulses, and returns the block to normal execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smi_req | input | 1 | Management interrupt request, level |
| io_trap | input | 1 | An I/O instruction is being trapped with the request |
| io_valid | input | 1 | The trapped I/O instruction is valid |
| dbg_hit | input | 1 | Breakpoint hit coinciding with the request |
| slot_wr | input | 1 | Handler write strobe for the restart slot |
| slot_wdata | input | 32 | Handler write data for the restart slot |
| rsm | input | 1 | Resume strobe |
| in_smm | output | 1 | Block is in system management mode |
| slot_rdata | output | 32 | Restart slot read value |
| trap_dw | output | 32 | Trap doubleword, bit 1 = valid trapped I/O |
| wr_err | output | 1 | Sticky flag: re-execute code written without a valid trap |
| reexec_pulse | output | 1 | Re-execute the trapped I/O instruction |
| adv_pulse | output | 1 | Continue with the next instruction |
| dbg_pulse | output | 1 | Deliver the deferred breakpoint exception |

## Verification
The assertions assume the following about the inputs. `rsm` and `slot_wr` are only meaningful while `in_smm` is high. `smi_req` is a level that stays high until it is taken. `io_trap`, `io_valid` and `dbg_hit` only matter in the cycle in which a request is taken. The stimulus keeps to these rules. It drops the request in the first cycle that `in_smm` is seen high, and it drives `rsm` for exactly one cycle. A nested request is raised together with `rsm` and held over the resume-decision cycle. The sweep covers every combination of trap, valid and breakpoint inputs, four handler write patterns, and nesting on or off.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int unsigned SLOT_W   = 32;
  localparam int unsigned CODE_W   = 16;
  localparam int unsigned TRAP_BIT = 1;
  localparam logic [CODE_W-1:0] CODE_REEXEC = 16'h00FF;
  localparam logic [CODE_W-1:0] CODE_NEXT   = 16'h0000;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SMM    = 3'd1,
    ST_POST   = 3'd2,
    ST_REEXEC = 3'd3,
    ST_ADV    = 3'd4,
    ST_DBG    = 3'd5
  } seq_state_e;
endpackage

// File: rtl/smm_slot.sv
module smm_slot
  import smm_pkg::*;
#(
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  input  logic          trap_ok,
  output logic [CW-1:0] code,
  output logic          err
);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] code_q, code_d;
  logic          err_q, err_d;
  logic          bad_wr;

  assign bad_wr = wr_en && (wdata == CODE_REEXEC[CW-1:0]) && !trap_ok;

  always_comb begin
    code_d = code_q;
    err_d  = err_q;
    if (clr) begin
      code_d = ZERO;
    end else if (bad_wr) begin
      err_d = 1'b1;
    end else if (wr_en) begin
      code_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= ZERO;
      err_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      err_q  <= err_d;
    end
  end

  assign code = code_q;
  assign err  = err_q;

  AST_BAD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && !clr) |=> (err && code != CODE_REEXEC[CW-1:0])); // R7

  AST_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (code == ZERO)); // R2
endmodule

// File: rtl/smm_seq.sv
module smm_seq
  import smm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smi_req,
  input  logic io_trap,
  input  logic io_valid,
  input  logic dbg_hit,
  input  logic rsm,
  input  logic restart_armed,
  output logic in_smm,
  output logic entry,
  output logic trap_valid,
  output logic reexec_p,
  output logic adv_p,
  output logic dbg_p
);
  seq_state_e state_q, state_d;
  logic tv_q, tv_d;
  logic prst_q, prst_d;
  logic pdbg_q, pdbg_d;

  always_comb begin
    state_d = state_q;
    tv_d    = tv_q;
    prst_d  = prst_q;
    pdbg_d  = pdbg_q;
    entry   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (smi_req) begin
          state_d = ST_SMM;
          entry   = 1'b1;
          tv_d    = io_trap && io_valid;
          pdbg_d  = dbg_hit;
          prst_d  = 1'b0;
        end
      end
      ST_SMM: begin
        if (rsm) begin
          state_d = ST_POST;
          prst_d  = prst_q || restart_armed;
        end
      end
      ST_POST: begin
        if (smi_req) begin
          state_d = ST_SMM;
          entry   = 1'b1;
          tv_d    = 1'b0;
        end else if (prst_q) begin
          state_d = ST_REEXEC;
        end else begin
          state_d = ST_ADV;
        end
      end
      ST_REEXEC: begin
        prst_d  = 1'b0;
        state_d = pdbg_q ? ST_DBG : ST_RUN;
      end
      ST_ADV: begin
        state_d = pdbg_q ? ST_DBG : ST_RUN;
      end
      ST_DBG: begin
        pdbg_d  = 1'b0;
        state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      tv_q    <= 1'b0;
      prst_q  <= 1'b0;
      pdbg_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tv_q    <= tv_d;
      prst_q  <= prst_d;
      pdbg_q  <= pdbg_d;
    end
  end

  assign in_smm     = (state_q == ST_SMM);
  assign trap_valid = tv_q;
  assign reexec_p   = (state_q == ST_REEXEC);
  assign adv_p      = (state_q == ST_ADV);
  assign dbg_p      = (state_q == ST_DBG);

  AST_NESTED_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POST && smi_req) |=> (in_smm && !trap_valid)); // R5

  AST_DBG_AFTER_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_p |-> $past(reexec_p || adv_p)); // R6
endmodule

// File: rtl/smm_restart_seq.sv
module smm_restart_seq
  import smm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_req,
  input  logic              io_trap,
  input  logic              io_valid,
  input  logic              dbg_hit,
  input  logic              slot_wr,
  input  logic [SLOT_W-1:0] slot_wdata,
  input  logic              rsm,
  output logic              in_smm,
  output logic [SLOT_W-1:0] slot_rdata,
  output logic [SLOT_W-1:0] trap_dw,
  output logic              wr_err,
  output logic              reexec_pulse,
  output logic              adv_pulse,
  output logic              dbg_pulse
);
  localparam int unsigned RSVD_W = SLOT_W - CODE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sn;
  logic              entry;
  logic              trap_valid;
  logic [CODE_W-1:0] code;
  logic              unused_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign unused_rsvd = ^slot_wdata[SLOT_W-1:CODE_W];

  smm_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_sn),
    .smi_req       (smi_req),
    .io_trap       (io_trap),
    .io_valid      (io_valid),
    .dbg_hit       (dbg_hit),
    .rsm           (rsm),
    .restart_armed (code == CODE_REEXEC),
    .in_smm        (in_smm),
    .entry         (entry),
    .trap_valid    (trap_valid),
    .reexec_p      (reexec_pulse),
    .adv_p         (adv_pulse),
    .dbg_p         (dbg_pulse)
  );

  smm_slot #(.CW(CODE_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr     (entry),
    .wr_en   (slot_wr && in_smm),
    .wdata   (slot_wdata[CODE_W-1:0]),
    .trap_ok (trap_valid),
    .code    (code),
    .err     (wr_err)
  );

  assign slot_rdata = {{RSVD_W{1'b0}}, code};

  always_comb begin
    trap_dw           = '0;
    trap_dw[TRAP_BIT] = trap_valid;
  end

  AST_ENTRY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(in_smm) |-> $past(smi_req)); // R1

  AST_ENTRY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(in_smm) |-> (slot_rdata == '0)); // R2
endmodule

// File: tb/sim_smm_restart_seq.sv
module sim_smm_restart_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smi_req, io_trap, io_valid, dbg_hit, slot_wr, rsm;
  logic [31:0] slot_wdata;
  logic        in_smm, wr_err, reexec_pulse, adv_pulse, dbg_pulse;
  logic [31:0] slot_rdata, trap_dw;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  smm_restart_seq u0 (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .io_trap(io_trap),
    .io_valid(io_valid), .dbg_hit(dbg_hit), .slot_wr(slot_wr),
    .slot_wdata(slot_wdata), .rsm(rsm), .in_smm(in_smm),
    .slot_rdata(slot_rdata), .trap_dw(trap_dw), .wr_err(wr_err),
    .reexec_pulse(reexec_pulse), .adv_pulse(adv_pulse), .dbg_pulse(dbg_pulse)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smi_req = 0; io_trap = 0; io_valid = 0; dbg_hit = 0;
    slot_wr = 0; slot_wdata = '0; rsm = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R9", "in_smm after reset", {31'b0, in_smm}, 32'd0);
    chk("R9", "slot after reset", slot_rdata, 32'd0);
    chk("R9", "trap_dw after reset", trap_dw, 32'd0);
    chk("R9", "pulses after reset", {29'b0, reexec_pulse, adv_pulse, dbg_pulse}, 32'd0);
    chk("R9", "wr_err after reset", {31'b0, wr_err}, 32'd0);

    for (int sc = 0; sc < 64; sc++) begin
      logic t, v, d, nest, valid, restart, err_exp;
      logic [31:0] wval;
      logic [15:0] code_exp;
      int wk;
      t = sc[0]; v = sc[1]; d = sc[2]; nest = sc[3]; wk = (sc >> 4) & 3;
      valid = t & v;
      do_reset();

      // R8: write outside SMM is ignored
      slot_wr = 1; slot_wdata = 32'hFFFF00FF;
      @(negedge clk);
      slot_wr = 0;
      chk("R8", "slot after write outside smm", slot_rdata, 32'd0);
      chk("R8", "wr_err after write outside smm", {31'b0, wr_err}, 32'd0);

      smi_req = 1; io_trap = t; io_valid = v; dbg_hit = d;
      @(negedge clk);
      smi_req = 0; io_trap = 0; io_valid = 0; dbg_hit = 0;
      chk("R1", "in_smm after request", {31'b0, in_smm}, 32'd1);
      chk("R2", "slot on entry", slot_rdata, 32'd0);
      chk("R3", "trap_dw on entry", trap_dw, {30'b0, valid, 1'b0});
      chk("R6", "no dbg pulse in smm", {31'b0, dbg_pulse}, 32'd0);

      case (wk)
        1:       wval = 32'hFFFF0000;
        2:       wval = 32'h5A5A00FF;
        3:       wval = 32'hABCD1234;
        default: wval = 32'h0;
      endcase
      code_exp = 16'h0000;
      err_exp  = 1'b0;
      if (wk == 2) begin
        if (valid) code_exp = 16'h00FF;
        else       err_exp  = 1'b1;
      end else if (wk == 3) begin
        code_exp = 16'h1234;
      end
      if (wk != 0) begin
        slot_wr = 1; slot_wdata = wval;
        @(negedge clk);
        slot_wr = 0;
      end
      chk("R2", "slot after handler write", slot_rdata, {16'h0, code_exp});
      chk("R7", "wr_err after handler write", {31'b0, wr_err}, {31'b0, err_exp});
      restart = (code_exp == 16'h00FF);

      rsm = 1; smi_req = nest;
      @(negedge clk);
      rsm = 0;

      if (nest) begin
        @(negedge clk);
        smi_req = 0;
        chk("R5", "nested entry taken", {31'b0, in_smm}, 32'd1);
        chk("R5", "nested trap bit clear", trap_dw, 32'd0);
        chk("R2", "nested slot cleared", slot_rdata, 32'd0);
        chk("R5", "no pulse before nested service", {29'b0, reexec_pulse, adv_pulse, dbg_pulse}, 32'd0);
        slot_wr = 1; slot_wdata = 32'h000000FF;
        @(negedge clk);
        slot_wr = 0;
        chk("R7", "nested restart write ignored", slot_rdata, 32'd0);
        chk("R7", "nested restart write flags error", {31'b0, wr_err}, 32'd1);
        rsm = 1;
        @(negedge clk);
        rsm = 0;
      end

      for (int i = 1; i <= 4; i++) begin
        logic er, ea, ed;
        @(negedge clk);
        er = (i == 1) && restart;
        ea = (i == 1) && !restart;
        ed = (i == 2) && d;
        chk("R4", $sformatf("reexec pulse cycle %0d", i), {31'b0, reexec_pulse}, {31'b0, er});
        chk("R4", $sformatf("adv pulse cycle %0d", i), {31'b0, adv_pulse}, {31'b0, ea});
        chk("R6", $sformatf("dbg pulse cycle %0d", i), {31'b0, dbg_pulse}, {31'b0, ed});
      end
      chk("R5", "back in normal execution", {31'b0, in_smm}, 32'd0);
      chk("R7", "sticky wr_err at end", {31'b0, wr_err}, {31'b0, err_exp | nest});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule